// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

This block keeps a free-running 64-bit count of nanoseconds for precision time protocol timestamping. On every enabled clock cycle it adds a programmable fixed-point increment. The increment has an integer nanosecond part and a 32-bit fraction. A 32-bit fraction accumulator carries into the nanosecond count, so rounding loses no time over many cycles. Timestamp capture logic elsewhere samples the live count on `tod_ns`.

Software reaches the block through a 32-bit valid-strobe register port. Every 64-bit quantity is moved as two words, low word first. Reading the low time word captures the whole time, so the next read of the high word is consistent with it. Writing a low word only stages it, and the write of the high word commits the full 64-bit value in one cycle. Software trims the frequency by rewriting the increment. An increment of zero stops the clock, which is what software loads when the link rate cannot be timestamped.

Top module: `ptp_tod_counter`

## Requirements
- R1: While `rst` is high, on each clock edge the time, the fraction accumulator, both staging words and the read snapshot are cleared, the enable bit is cleared, and the increment takes the value of parameter `INC_RESET` (default 0x0000_0001_9999_9999).
- R2: The time changes only on a clock edge where the enable bit (address 0, bit 0, read and write) is set, or on a committed time write. With the bit clear the time holds.
- R3: The increment is 64 bits. The high word holds integer nanoseconds and the low word holds the fraction in units of 2^-32 ns. Each enabled cycle adds the fraction to the accumulator and adds the integer part plus the accumulator carry to the time.
- R4: A committed increment of zero keeps the time constant even while enabled.
- R5: A read of address 1 returns the low 32 bits of the time as it was before that clock edge, and captures all 64 bits. A later read of address 2 returns the upper half of that capture, not the live time.
- R6: A write to address 1 only stages the word and leaves the time unchanged. A write to address 2 loads {written word, staged word} into the time and clears the fraction accumulator.
- R7: A write to address 3 stages the increment low word. A write to address 4 commits {written word, staged word} as the increment. Reads of addresses 3 and 4 return the committed increment halves.
- R8: When a time commit and an enabled tick fall in the same cycle, the written value is loaded and the increment is not added in that cycle.
- R9: `rvalid` is high exactly in the cycle after a cycle with `rd_en` high, and `rdata` carries the read result in that cycle.
- R10: `tod_ns` always shows the live time register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register select: 0 control, 1/2 time low/high, 3/4 increment low/high |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | Read data valid, one cycle after `rd_en` |
| tod_ns | output | 64 | Live nanosecond time |

## Verification
The counter is run from a known start for a known number of ticks with several increments. An exact integer of 1 ns shows plain counting. A half nanosecond exposes the fraction path. The 1.6 ns and 3.2 ns values show truncation against the accumulated fraction, and since the second follows the first, they also show whether a time write clears the leftover fraction. A 32 ns value exercises a wide integer step, a zero increment must freeze the count, and a start just below a 32-bit boundary checks carry into the high word. Directed cases cover a stale high-word read after the time crosses that boundary, lone low-word writes to both staged registers, a time commit that collides with a tick, and reset in mid-run.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_CTRL    = 3'd0,
    REG_TIME_LO = 3'd1,
    REG_TIME_HI = 3'd2,
    REG_INC_LO  = 3'd3,
    REG_INC_HI  = 3'd4
  } reg_sel_e;

  localparam int CTRL_EN_BIT = 0;
endpackage

// File: rtl/ptp_tod_regport.sv
module ptp_tod_regport
  import ptp_tod_pkg::*;
#(
  parameter int            WORD_W    = 32,
  parameter logic [63:0]   INC_RESET = 64'h0000_0001_9999_9999,
  localparam int           DWORD_W   = 2 * WORD_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0]     wdata,
  input  logic [DWORD_W-1:0]    live_time,
  output logic [WORD_W-1:0]     rdata,
  output logic                  rvalid,
  output logic                  en_q,
  output logic [DWORD_W-1:0]    inc_q,
  output logic                  time_ld,
  output logic [DWORD_W-1:0]    time_ld_val
);

  logic [WORD_W-1:0]  time_stage_q;
  logic [WORD_W-1:0]  inc_stage_q;
  logic [DWORD_W-1:0] snap_q;

  logic wr_ctrl, wr_tlo, wr_thi, wr_ilo, wr_ihi;
  logic rd_tlo;

  always_comb begin
    wr_ctrl = wr_en && (addr == REG_CTRL);
    wr_tlo  = wr_en && (addr == REG_TIME_LO);
    wr_thi  = wr_en && (addr == REG_TIME_HI);
    wr_ilo  = wr_en && (addr == REG_INC_LO);
    wr_ihi  = wr_en && (addr == REG_INC_HI);
    rd_tlo  = rd_en && (addr == REG_TIME_LO);
  end

  assign time_ld     = wr_thi;
  assign time_ld_val = {wdata, time_stage_q};

  // write side: staging words and committed control state
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q         <= 1'b0;
      time_stage_q <= '0;
      inc_stage_q  <= '0;
      inc_q        <= INC_RESET[DWORD_W-1:0];
    end else begin
      if (wr_ctrl) en_q         <= wdata[CTRL_EN_BIT];
      if (wr_tlo)  time_stage_q <= wdata;
      if (wr_ilo)  inc_stage_q  <= wdata;
      if (wr_ihi)  inc_q        <= {wdata, inc_stage_q};
    end
  end

  // read side: snapshot on low-word read, registered return data
  logic [WORD_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (addr == REG_CTRL)         rd_mux[CTRL_EN_BIT] = en_q;
    else if (addr == REG_TIME_LO) rd_mux = live_time[WORD_W-1:0];
    else if (addr == REG_TIME_HI) rd_mux = snap_q[DWORD_W-1:WORD_W];
    else if (addr == REG_INC_LO)  rd_mux = inc_q[WORD_W-1:0];
    else if (addr == REG_INC_HI)  rd_mux = inc_q[DWORD_W-1:WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en)  rdata  <= rd_mux;
      if (rd_tlo) snap_q <= live_time;
    end
  end

endmodule

// File: rtl/ptp_tod_core.sv
module ptp_tod_core #(
  parameter int NS_W   = 64,
  parameter int INT_W  = 32,
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [INT_W-1:0]  inc_int,
  input  logic [FRAC_W-1:0] inc_frac,
  input  logic              ld,
  input  logic [NS_W-1:0]   ld_val,
  output logic [NS_W-1:0]   ns_q
);

  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W:0]   frac_sum;
  logic [NS_W-1:0]   ns_next;

  always_comb begin
    frac_sum = {1'b0, frac_q} + {1'b0, inc_frac};
    ns_next  = ns_q + NS_W'(inc_int) + NS_W'(frac_sum[FRAC_W]);
  end

  // a commit overrides a tick in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      ns_q   <= '0;
      frac_q <= '0;
    end else if (ld) begin
      ns_q   <= ld_val;
      frac_q <= '0;
    end else if (en) begin
      ns_q   <= ns_next;
      frac_q <= frac_sum[FRAC_W-1:0];
    end
  end

endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import ptp_tod_pkg::*;
#(
  parameter int          WORD_W    = 32,
  parameter logic [63:0] INC_RESET = 64'h0000_0001_9999_9999,
  localparam int         NS_W      = 2 * WORD_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0]     wdata,
  output logic [WORD_W-1:0]     rdata,
  output logic                  rvalid,
  output logic [NS_W-1:0]       tod_ns
);

  logic            en_q;
  logic [NS_W-1:0] inc_q;
  logic            time_ld;
  logic [NS_W-1:0] time_ld_val;

  ptp_tod_regport #(
    .WORD_W    (WORD_W),
    .INC_RESET (INC_RESET)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .live_time   (tod_ns),
    .rdata       (rdata),
    .rvalid      (rvalid),
    .en_q        (en_q),
    .inc_q       (inc_q),
    .time_ld     (time_ld),
    .time_ld_val (time_ld_val)
  );

  ptp_tod_core #(
    .NS_W   (NS_W),
    .INT_W  (WORD_W),
    .FRAC_W (WORD_W)
  ) u_core (
    .clk      (clk),
    .rst      (rst),
    .en       (en_q),
    .inc_int  (inc_q[NS_W-1:WORD_W]),
    .inc_frac (inc_q[WORD_W-1:0]),
    .ld       (time_ld),
    .ld_val   (time_ld_val),
    .ns_q     (tod_ns)
  );

endmodule

// File: rtl/ptp_tod_checker.sv
module ptp_tod_checker
  import ptp_tod_pkg::*;
#(
  parameter int  WORD_W = 32,
  localparam int NS_W   = 2 * WORD_W
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [REG_ADDR_W-1:0] addr,
  input logic [WORD_W-1:0]     wdata,
  input logic                  rvalid,
  input logic [NS_W-1:0]       tod_ns,
  input logic                  en_q,
  input logic [NS_W-1:0]       inc_q
);

  logic commit;
  assign commit = wr_en && (addr == REG_TIME_HI);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (tod_ns == '0) && !en_q); // R1

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !commit) |=> $stable(tod_ns)); // R2

  AST_NEVER_BACKWARD: assert property (@(posedge clk) disable iff (rst)
    (en_q && !commit) |=> (tod_ns >= $past(tod_ns))); // R3

  AST_ZERO_INC_FREEZE: assert property (@(posedge clk) disable iff (rst)
    ((inc_q == '0) && !commit) |=> $stable(tod_ns)); // R4

  AST_HI_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
    commit |=> (tod_ns[NS_W-1:WORD_W] == $past(wdata))); // R8

  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid); // R9

  AST_RVALID_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rvalid); // R9

endmodule

bind ptp_tod_counter ptp_tod_checker #(.WORD_W(WORD_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .addr   (addr),
  .wdata  (wdata),
  .rvalid (rvalid),
  .tod_ns (tod_ns),
  .en_q   (en_q),
  .inc_q  (inc_q)
);

// File: tb/tb_ptp_tod_counter.sv
`timescale 1ns/1ps
module tb_ptp_tod_counter;
  import ptp_tod_pkg::*;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        rvalid;
  logic [63:0] tod_ns;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  ptp_tod_counter dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .tod_ns(tod_ns)
  );

  localparam int N_VEC = 7;
  localparam logic [63:0] V_START [N_VEC] = '{
    64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0000_0000_FFFF_FFFE};
  localparam logic [63:0] V_INC [N_VEC] = '{
    64'h0000_0001_0000_0000, 64'h0000_0000_8000_0000, 64'h0000_0001_9999_9999,
    64'h0000_0003_3333_3333, 64'h0000_0020_0000_0000, 64'h0,
    64'h0000_0001_0000_0000};
  localparam int V_TICKS [N_VEC] = '{10, 10, 10, 6, 4, 20, 5};
  localparam logic [63:0] V_EXP [N_VEC] = '{
    64'd10, 64'd5, 64'd15, 64'd19, 64'd128, 64'd0, 64'h0000_0001_0000_0003};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic bus_write(input reg_sel_e a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input reg_sel_e a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    checks++;
    if (rvalid !== 1'b1) begin
      fails++;
      $display("FAIL R9 rvalid actual=%b expected=1", rvalid);
    end
    d = rdata;
  endtask

  task automatic read_time(output logic [63:0] t);
    logic [31:0] lo, hi;
    bus_read(REG_TIME_LO, lo);
    bus_read(REG_TIME_HI, hi);
    t = {hi, lo};
  endtask

  task automatic set_time(input logic [63:0] t);
    bus_write(REG_TIME_LO, t[31:0]);
    bus_write(REG_TIME_HI, t[63:32]);
  endtask

  task automatic set_inc(input logic [63:0] v);
    bus_write(REG_INC_LO, v[31:0]);
    bus_write(REG_INC_HI, v[63:32]);
  endtask

  // exactly n enabled clock edges
  task automatic run_ticks(input int n);
    bus_write(REG_CTRL, 32'd1);
    repeat (n - 1) @(negedge clk);
    bus_write(REG_CTRL, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] t, t2;
    logic [31:0] w;
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    chk("R1 rvalid after reset", {63'b0, rvalid}, 64'd0);
    chk("R10 tod_ns after reset", tod_ns, 64'd0);
    read_time(t);        chk("R1 time", t, 64'd0);
    bus_read(REG_CTRL, w);   chk("R1 enable", {32'b0, w}, 64'd0);
    bus_read(REG_INC_LO, w); chk("R1 inc lo", {32'b0, w}, 64'h9999_9999);
    bus_read(REG_INC_HI, w); chk("R1 inc hi", {32'b0, w}, 64'd1);

    // R3 R4 R6 vector table
    for (int i = 0; i < N_VEC; i++) begin
      set_inc(V_INC[i]);
      set_time(V_START[i]);
      run_ticks(V_TICKS[i]);
      read_time(t);
      chk($sformatf("R3 R4 R6 vector %0d", i), t, V_EXP[i]);
      chk($sformatf("R10 vector %0d", i), tod_ns, V_EXP[i]);
    end

    // R2 disabled clock holds
    read_time(t);
    repeat (10) @(negedge clk);
    read_time(t2);
    chk("R2 frozen while disabled", t2, t);

    // R5 high-word read returns captured half
    set_inc(64'h0000_0001_0000_0000);
    set_time(64'h0000_0001_FFFF_FFF8);
    bus_write(REG_CTRL, 32'd1);
    bus_read(REG_TIME_LO, w);
    chk("R5 low word", {32'b0, w}, 64'hFFFF_FFF8);
    repeat (20) @(negedge clk);
    bus_read(REG_TIME_HI, w);
    chk("R5 stale high word", {32'b0, w}, 64'd1);
    chk("R10 live high moved", {32'b0, tod_ns[63:32]}, 64'd2);
    bus_write(REG_CTRL, 32'd0);

    // R6 low-word time write alone has no effect
    set_time(64'h0000_0000_0000_0100);
    bus_write(REG_TIME_LO, 32'hDEAD_BEEF);
    read_time(t);
    chk("R6 staged low ignored", t, 64'h100);
    bus_write(REG_TIME_HI, 32'h0000_0007);
    read_time(t);
    chk("R6 high commit", t, 64'h0000_0007_DEAD_BEEF);

    // R7 staged increment
    set_inc(64'h0000_0001_0000_0000);
    set_time(64'h0);
    bus_write(REG_INC_LO, 32'h8000_0000);
    bus_read(REG_INC_LO, w);
    chk("R7 inc lo still committed", {32'b0, w}, 64'd0);
    run_ticks(4);
    read_time(t);
    chk("R7 old inc in effect", t, 64'd4);
    bus_write(REG_INC_HI, 32'h0);
    bus_read(REG_INC_LO, w);
    chk("R7 inc lo committed", {32'b0, w}, 64'h8000_0000);
    set_time(64'h0);
    run_ticks(4);
    read_time(t);
    chk("R7 new inc in effect", t, 64'd2);

    // R8 commit wins over tick
    set_inc(64'h0000_0001_0000_0000);
    bus_write(REG_TIME_LO, 32'h10);
    bus_write(REG_CTRL, 32'd1);
    bus_write(REG_TIME_HI, 32'h5);
    bus_write(REG_CTRL, 32'd0);
    read_time(t);
    chk("R8 collision", t, 64'h0000_0005_0000_0011);

    // R1 reset in mid-run
    set_inc(64'h0000_0002_0000_0000);
    bus_write(REG_CTRL, 32'd1);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    read_time(t);            chk("R1 time after mid reset", t, 64'd0);
    bus_read(REG_CTRL, w);   chk("R1 enable after mid reset", {32'b0, w}, 64'd0);
    bus_read(REG_INC_HI, w); chk("R1 inc after mid reset", {32'b0, w}, 64'd1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule